// File: doc/BRIEF.md
# I2C Controller Interrupt Register Unit

This block collects the event pulses of an I2C bus controller into one processor interrupt line. Each of eight single-cycle event inputs latches into its own bit of a sticky status register. A per-bit enable register selects which latched events may raise the interrupt. A single global-enable bit, at the top of its own word, gates the OR of the enabled status bits. The gated result is registered and driven out as a level-sensitive interrupt.

Software reaches all three registers through a plain 32-bit port. The port has a one-cycle write strobe and a one-cycle read strobe, and read data is registered. Software clears the status register by toggle-on-write: writing a 1 to a bit position flips that bit, and writing a 0 leaves it alone. An interrupt handler can therefore clear exactly the events it served by writing back the value it read, with no read-modify-write. When a hardware event and a software toggle land on the same bit in the same cycle, the hardware event wins.

The shifter, FIFOs and arbitration logic that produce the events are outside this block. Here they are only pulse inputs.

Top module: `i2c_irq_regs`

## Requirements
- R1: After reset the status, enable and global-enable registers are all zero and `irq` is 0.
- R2: The global-enable register is at byte offset 0x01C and holds a single bit in bit 31. Writes to bits 30..0 are discarded, and reads return those bits as zero.
- R3: While the global enable is 0, `irq` stays 0 whatever the status and enable registers hold.
- R4: While the global enable is 1, `irq` equals the OR over all bits of (status AND enable). `irq` is registered: it takes a new value on the clock edge that follows the edge on which status, enable or global enable changed.
- R5: A 1 on `evt_pulse[i]` sets status bit i on that clock edge, and the bit stays set until software toggles it. The bit map, shared by status and enable, is:
  - bit 0: arbitration lost
  - bit 1: transmit error or slave transmit complete
  - bit 2: transmit FIFO empty
  - bit 3: receive FIFO full
  - bit 4: bus not busy
  - bit 5: addressed as slave
  - bit 6: not addressed as slave
  - bit 7: transmit FIFO half empty
- R6: A write to the status register at offset 0x020 inverts every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R7: If an event pulse and a toggling write reach the same status bit in the same cycle, the bit ends at 1.
- R8: The enable register at offset 0x028 is read/write in bits 7..0. In both the enable and the status register, bits 31..8 read as zero.
- R9: A read strobe returns the addressed register on `reg_rdata` in the cycle after the strobe. A read has no side effect. `reg_rdata` is zero in any cycle that does not follow a read strobe. A read of any other offset returns zero, and a read issued together with a write returns the value the register held before the write.
- R10: A write to any offset other than 0x01C, 0x020 or 0x028 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | Event pulses, one bit per status bit |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench builds the block with its default parameters: eight events, a 32-bit data word and an 8-bit address. With eight events the status space has only 256 values, so the bench sweeps every status pattern. It sets each pattern through toggle writes and pairs it with several enable masks under both global-enable settings. The small event count also lets the bench check every single-bit pulse, the hardware-wins collision, the one-cycle interrupt latency and the unmapped offsets one by one.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

   // Which register a port access addresses
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_GLB  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_MASK = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
   import i2c_irq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFS_GLB  = 'h1C,
   parameter int OFS_STAT = 'h20,
   parameter int OFS_MASK = 'h28
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(OFS_GLB);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   if ((OFS_GLB == OFS_STAT) || (OFS_GLB == OFS_MASK) || (OFS_STAT == OFS_MASK)) begin : g_bad_map
      $error("i2c_irq_decode: register offsets must be distinct");
   end
   if ((OFS_GLB % 4 != 0) || (OFS_STAT % 4 != 0) || (OFS_MASK % 4 != 0)) begin : g_bad_align
      $error("i2c_irq_decode: register offsets must be word aligned");
   end

   always_comb begin
      if (addr == A_GLB)       sel = SEL_GLB;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_MASK) sel = SEL_MASK;
      else                     sel = SEL_NONE;
   end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [NUM_EVT-1:0] tog,
   output logic [NUM_EVT-1:0] stat
);

   // One sticky cell per event; a hardware set beats a software toggle
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cell_q <= 1'b0;
         else if (evt[i]) cell_q <= 1'b1;
         else if (tog[i]) cell_q <= ~cell_q;
      end
      assign stat[i] = cell_q;
   end

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mask_we,
   input  logic [NUM_EVT-1:0] mask_d,
   input  logic               glb_we,
   input  logic               glb_d,
   output logic [NUM_EVT-1:0] mask,
   output logic               glb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
         glb  <= 1'b0;
      end else begin
         if (mask_we) mask <= mask_d;
         if (glb_we)  glb  <= glb_d;
      end
   end

endmodule

// File: rtl/i2c_irq_out.sv
module i2c_irq_out #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] stat,
   input  logic [NUM_EVT-1:0] mask,
   input  logic               glb,
   output logic               irq
);

   logic pending;
   assign pending = |(stat & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= glb & pending;
   end

endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
   import i2c_irq_pkg::*;
#(
   parameter int NUM_EVT  = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int OFS_GLB  = 'h1C,
   parameter int OFS_STAT = 'h20,
   parameter int OFS_MASK = 'h28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq
);

   localparam int GLB_BIT = DATA_W - 1;
   localparam int PAD_W   = DATA_W - NUM_EVT;

   if (NUM_EVT < 1 || NUM_EVT >= DATA_W) begin : g_bad_width
      $error("i2c_irq_regs: NUM_EVT must lie in 1..DATA_W-1");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("i2c_irq_regs: ADDR_W too narrow for the register offsets");
   end

   reg_sel_e           sel;
   logic [NUM_EVT-1:0] stat;
   logic [NUM_EVT-1:0] mask;
   logic               glb;
   logic [NUM_EVT-1:0] tog;
   logic [DATA_W-1:0]  rd_mux;
   logic               unused_wdata;

   assign unused_wdata = ^reg_wdata[GLB_BIT-1:NUM_EVT];

   i2c_irq_decode #(
      .ADDR_W(ADDR_W), .OFS_GLB(OFS_GLB), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   assign tog = (reg_wr && sel == SEL_STAT) ? reg_wdata[NUM_EVT-1:0] : '0;

   i2c_irq_status #(.NUM_EVT(NUM_EVT)) u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt_pulse),
      .tog  (tog),
      .stat (stat)
   );

   i2c_irq_ctrl #(.NUM_EVT(NUM_EVT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_we(reg_wr && sel == SEL_MASK),
      .mask_d (reg_wdata[NUM_EVT-1:0]),
      .glb_we (reg_wr && sel == SEL_GLB),
      .glb_d  (reg_wdata[GLB_BIT]),
      .mask   (mask),
      .glb    (glb)
   );

   i2c_irq_out #(.NUM_EVT(NUM_EVT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .stat (stat),
      .mask (mask),
      .glb  (glb),
      .irq  (irq)
   );

   always_comb begin
      unique case (sel)
         SEL_GLB:  rd_mux = {glb, {GLB_BIT{1'b0}}};
         SEL_STAT: rd_mux = {{PAD_W{1'b0}}, stat};
         SEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
      else             reg_rdata <= '0;
   end

endmodule

// File: rtl/i2c_irq_regs_chk.sv
module i2c_irq_regs_chk #(
   parameter int NUM_EVT  = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int OFS_STAT = 'h20,
   parameter int OFS_MASK = 'h28
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               irq,
   input logic [NUM_EVT-1:0] stat,
   input logic               glb
);

   // R3: with the global enable clear, the next output value is low
   assert_glb_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !glb |=> !irq);

   // R5: every pulsed event is latched on the edge it arrives
   assert_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((stat & $past(evt_pulse)) == $past(evt_pulse)));

   // R6: without events or writes the status register holds
   assert_status_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && evt_pulse == '0) |=> $stable(stat));

   // R8: reserved high bits of status and enable never read as one
   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == ADDR_W'(OFS_STAT) || reg_addr == ADDR_W'(OFS_MASK)))
      |=> (reg_rdata[DATA_W-1:NUM_EVT] == '0));

   // R9: read data is zero in a cycle that does not follow a read strobe
   assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));

endmodule

bind i2c_irq_regs i2c_irq_regs_chk #(
   .NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_pulse(evt_pulse),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .irq      (irq),
   .stat     (stat),
   .glb      (glb)
);

// File: tb/i2c_irq_regs_test.sv
module i2c_irq_regs_test;

   localparam logic [7:0] A_GLB  = 8'h1C;
   localparam logic [7:0] A_STAT = 8'h20;
   localparam logic [7:0] A_MASK = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_pulse = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_stat = '0;
   logic [7:0] exp_mask = '0;
   logic       exp_glb  = 1'b0;

   always #5 clk = ~clk;

   i2c_irq_regs uut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, let one rising edge take the access
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic exp_irq();
      return exp_glb && ((exp_stat & exp_mask) != 8'h00);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(A_STAT, v); chk("R1 status", v, 32'd0);
      rd(A_MASK, v); chk("R1 enable", v, 32'd0);
      rd(A_GLB, v);  chk("R1 global", v, 32'd0);
      chk("R9 idle rdata", reg_rdata, 32'd0);

      // R2: only bit 31 of the global word exists
      wr(A_GLB, 32'hFFFF_FFFF); exp_glb = 1'b1;
      rd(A_GLB, v); chk("R2 global set", v, 32'h8000_0000);
      wr(A_GLB, 32'h7FFF_FFFF); exp_glb = 1'b0;
      rd(A_GLB, v); chk("R2 global low bits ignored", v, 32'd0);

      // R8: enable read/write, reserved bits zero
      wr(A_MASK, 32'hFFFF_FFFF); exp_mask = 8'hFF;
      rd(A_MASK, v); chk("R8 enable all", v, 32'h0000_00FF);
      wr(A_MASK, 32'h0000_005A); exp_mask = 8'h5A;
      rd(A_MASK, v); chk("R8 enable pattern", v, 32'h0000_005A);

      // R10: unmapped offsets change nothing and read as zero (R9)
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R10 status untouched", v, 32'd0);
      rd(A_MASK, v); chk("R10 enable untouched", v, 32'h0000_005A);
      rd(A_GLB, v);  chk("R10 global untouched", v, 32'd0);
      rd(8'h24, v);  chk("R9 unmapped read", v, 32'd0);

      // R3 / R4 / R6: every status pattern against several masks
      for (int s = 0; s < 256; s++) begin
         wr(A_STAT, {24'd0, exp_stat ^ 8'(s)}); exp_stat = 8'(s);
         rd(A_STAT, v); chk("R6 toggle to pattern", v, {24'd0, exp_stat});
         for (int k = 0; k < 4; k++) begin
            exp_mask = 8'((s * 29 + k * 85 + 7) & 255);
            wr(A_MASK, {24'd0, exp_mask});
            for (int g = 0; g < 2; g++) begin
               exp_glb = (g == 1);
               wr(A_GLB, {exp_glb, 31'd0});
               @(negedge clk);
               chk(exp_glb ? "R4 masked OR" : "R3 global off", {31'd0, irq}, {31'd0, exp_irq()});
            end
         end
      end

      // R4: one-cycle latency after the global bit rises
      wr(A_GLB, 32'd0); exp_glb = 1'b0;
      wr(A_STAT, {24'd0, exp_stat ^ 8'h01}); exp_stat = 8'h01;
      wr(A_MASK, 32'h0000_0001); exp_mask = 8'h01;
      @(negedge clk);
      wr(A_GLB, 32'h8000_0000); exp_glb = 1'b1;
      chk("R4 irq not yet", {31'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R4 irq one cycle later", {31'd0, irq}, 32'd1);

      // R5: each event sets its own bit and stays; irq follows one cycle later
      wr(A_STAT, 32'h0000_0001); exp_stat = 8'h00;
      wr(A_MASK, 32'h0000_00FF); exp_mask = 8'hFF;
      @(negedge clk);
      chk("R5 irq clear before events", {31'd0, irq}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         evt_pulse = 8'(1 << i);
         @(negedge clk);
         evt_pulse = '0;
         exp_stat = exp_stat | 8'(1 << i);
         if (i == 0) chk("R4 irq lags event", {31'd0, irq}, 32'd0);
         @(negedge clk);
         chk("R5 irq after event", {31'd0, irq}, 32'd1);
         rd(A_STAT, v); chk("R5 event bit sticky", v, {24'd0, exp_stat});
      end

      // R6: writing zeros leaves status; toggling a subset clears only it
      wr(A_STAT, 32'd0);
      rd(A_STAT, v); chk("R6 zero write no effect", v, 32'h0000_00FF);
      wr(A_STAT, 32'h0000_00A5); exp_stat = 8'h5A;
      rd(A_STAT, v); chk("R6 partial clear", v, 32'h0000_005A);

      // R7: event and toggle on the same bit, from 1 and from 0
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0000_000C;
      evt_pulse = 8'h0C;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
      rd(A_STAT, v); chk("R7 hardware set wins", v, 32'h0000_005E);

      // R9: read together with a write returns the old value; reads have no side effect
      @(negedge clk);
      reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = A_MASK; reg_wdata = 32'h0000_0033;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
      chk("R9 read before write", reg_rdata, 32'h0000_00FF);
      rd(A_MASK, v); chk("R9 write landed", v, 32'h0000_0033);
      rd(A_STAT, v); rd(A_STAT, v2);
      chk("R9 read has no side effect", v2, v);
      @(negedge clk);
      chk("R9 rdata zero when idle", reg_rdata, 32'd0);

      // R3: dropping the global bit silences a pending interrupt
      wr(A_GLB, 32'd0);
      @(negedge clk);
      chk("R3 irq off with pending status", {31'd0, irq}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule